// File: doc/BRIEF.md
# Power-Fail-Gated Memory Chip-Select Decoder

This block produces active-low chip selects for a memory that is kept alive by a battery when the main supply fails. It holds two 2-to-4 decoder halves. Each half has its own group enable, and the two group enables have opposite polarity. A shared active-low global enable and an active-low shutdown input act on both halves. When the two group enables are tied to one line and both halves are driven with the same address, that line becomes a third address bit, and the pair works as a 3-to-8 decoder.

A digital supply-good input takes the place of an analog voltage comparator. A loss of supply forces every select high at once, and it releases the supply-switch control output, which is active low. The input then passes through a synchronizer and a hold-off counter. The selects stay forced high for a fixed number of clock edges after the supply returns, so the memory never sees a select pulse while power recovers. The `REGISTERED` parameter chooses whether the decoded selects are driven combinationally or from flops. The supply-fail force acts at once in both cases.

Top module: `memsel_pwr_decoder`

## Requirements
- R1: With glb_en_n=0, grp1_en_n=0, shut_n=1 and the supply qualified, an addr1 value k drives sel1_n[k] low and the other three sel1_n bits high.
- R2: With glb_en_n=0, grp2_en=1, shut_n=1 and the supply qualified, an addr2 value k drives sel2_n[k] low and the other three sel2_n bits high.
- R3: A half's four outputs are all high whenever glb_en_n=1, or shut_n=0, or that half's group enable is inactive (grp1_en_n=1 for half 1, grp2_en=0 for half 2), whatever the address.
- R4: With grp1_en_n and grp2_en driven from one line c, and addr1 equal to addr2 = {b,a}, exactly one of the eight outputs {sel2_n,sel1_n} is low when enabled, at bit index {c,b,a}.
- R5: While supply_ok=0, all eight outputs and psw_n are high in the same cycle, whatever the other inputs are, in both output variants.
- R6: psw_n is low (switch on) while the supply is qualified good.
- R7: After supply_ok rises, or after reset is released with supply_ok high, the outputs stay high and psw_n stays high for SYNC_STAGES+HOLD_CYCLES rising clock edges. Decoding and psw_n=0 take effect after the last of those edges.
- R8: With REGISTERED=1, the decoded outputs change one rising edge after their inputs, except for the immediate force of R5.
- R9: At no time is more than one output of a half low, and when the group enables are driven independently both halves may decode at the same time.
- R10: While rst_n=0 at a rising edge, all outputs and psw_n are high from that edge on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the supply qualifier and the registered output path |
| rst_n | input | 1 | Synchronous active-low reset |
| supply_ok | input | 1 | Supply-good indication, may be asynchronous |
| shut_n | input | 1 | Active-low shutdown, forces all selects high |
| glb_en_n | input | 1 | Active-low global enable for both halves |
| grp1_en_n | input | 1 | Active-low group enable, half 1 |
| grp2_en | input | 1 | Active-high group enable, half 2 |
| addr1 | input | ADDR_W (2) | Address of half 1 |
| addr2 | input | ADDR_W (2) | Address of half 2 |
| sel1_n | output | 2**ADDR_W (4) | Active-low selects, half 1 |
| sel2_n | output | 2**ADDR_W (4) | Active-low selects, half 2 |
| psw_n | output | 1 | Supply-switch control, low = memory on system supply |

## Verification
Each half is driven through every address value, and the result is compared against a one-hot-low pattern. This shows that the address bits are not swapped and that the low output sits at the right index.

The enable inputs are then switched one at a time while the address is held at a decoding value. This shows that each gate, and each group-enable polarity, blocks the decode on its own.

A 3-to-8 sweep with the group enables tied together checks that the shared line picks the upper or lower half. Supply drops are applied while the inputs would otherwise select an output, and the recovery edges are then counted one by one. This shows both that the force is immediate and that the hold-off is exactly SYNC_STAGES+HOLD_CYCLES edges long, not one more or one less.

A registered instance runs beside the combinational one. It tells the one-edge lag of the decoded outputs apart from the immediate supply force.

// File: rtl/memsel_pkg.sv
// Package: shared types and helpers for the power-fail-gated select decoder.
// Assumes: callers pass an address narrower than 16 bits.
package memsel_pkg;

    // Common gating conditions that apply to both decoder halves.
    typedef struct packed {
        logic glb_en_n;   // active-low global enable
        logic shut_n;     // active-low shutdown
        logic pwr_gate;   // supply qualified and present
    } memsel_ctrl_t;

    // Returns 1 when the shared conditions allow any decoding at all.
    function automatic logic ctrl_allows(input memsel_ctrl_t c);
        return c.pwr_gate & c.shut_n & ~c.glb_en_n;
    endfunction

endpackage

// File: rtl/memsel_supply_qual.sv
// Module: supply qualifier.
// Synchronizes the asynchronous supply-good input through SYNC_STAGES flops,
// then requires HOLD_CYCLES further edges of a steady high level before it
// reports the supply as qualified.
// Assumes: SYNC_STAGES >= 2, HOLD_CYCLES >= 1, synchronous active-low reset.
module memsel_supply_qual #(
    parameter int SYNC_STAGES = 2,
    parameter int HOLD_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    output logic qual_ok
);
    localparam int CNT_W = $clog2(HOLD_CYCLES + 1);
    localparam int LIMIT = SYNC_STAGES + HOLD_CYCLES;
    localparam int RUN_W = $clog2(LIMIT + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CNT_W-1:0]       hold_cnt;
    logic                   hold_done;

    // Shift the supply-good level through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], supply_ok};
    end

    // Count synchronized high edges until the hold-off window has elapsed.
    always_ff @(posedge clk) begin
        if (!rst_n || !sync_q[SYNC_STAGES-1]) begin
            hold_cnt  <= '0;
            hold_done <= 1'b0;
        end else if (!hold_done) begin
            if (hold_cnt == CNT_W'(HOLD_CYCLES - 1)) hold_done <= 1'b1;
            else                                     hold_cnt  <= hold_cnt + 1'b1;
        end
    end

    // Qualified only while every stage agrees, so a drop is seen at once.
    always_comb qual_ok = hold_done & (&sync_q);

    // Checker: consecutive edges with the raw input high, saturating.
    logic [RUN_W-1:0] hi_run;
    always_ff @(posedge clk) begin
        if (!rst_n || !supply_ok)       hi_run <= '0;
        else if (hi_run != RUN_W'(LIMIT)) hi_run <= hi_run + 1'b1;
    end

    // R7: qualification never comes before the full recovery window.
    a_r7_hold_window: assert property (@(posedge clk) disable iff (!rst_n)
        qual_ok |-> (hi_run >= RUN_W'(LIMIT)));

endmodule

// File: rtl/memsel_half_dec.sv
// Module: one decoder half with active-low outputs.
// Decodes ADDR_W address bits to 2**ADDR_W selects when the shared control
// conditions and this half's group enable allow it. The group enable polarity
// is chosen by GRP_ACT_HIGH.
// Assumes: purely combinational; clk and rst_n are used only by assertions.
module memsel_half_dec
    import memsel_pkg::*;
#(
    parameter int ADDR_W       = 2,
    parameter bit GRP_ACT_HIGH = 1'b0,
    parameter int OUTS         = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  memsel_ctrl_t      ctrl,
    input  logic              grp_en,
    input  logic [ADDR_W-1:0] addr,
    output logic [OUTS-1:0]   sel_n
);
    logic grp_active;
    logic half_en;

    // Resolve the group enable polarity and combine it with the shared gates.
    always_comb begin
        grp_active = GRP_ACT_HIGH ? grp_en : ~grp_en;
        half_en    = ctrl_allows(ctrl) & grp_active;
    end

    // One comparator per output, driving it low only when selected.
    for (genvar i = 0; i < OUTS; i++) begin : g_out
        assign sel_n[i] = ~(half_en && (addr == ADDR_W'(i)));
    end

    // R9: at most one select of this half is low.
    a_r9_half_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~sel_n) <= 1);

    // R3: a blocked group enable leaves every select of this half high.
    a_r3_group_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        !grp_active |-> (&sel_n));

endmodule

// File: rtl/memsel_pwr_decoder.sv
// Module: top of the power-fail-gated memory chip-select decoder.
// Two decoder halves with opposite group-enable polarity share the global
// enable, the shutdown and the power gate. A supply loss forces all selects
// high and releases the supply switch immediately. Recovery waits for the
// qualifier. REGISTERED picks flopped or combinational decoded outputs.
// Assumes: supply_ok may be asynchronous; all other inputs are synchronous to clk.
module memsel_pwr_decoder
    import memsel_pkg::*;
#(
    parameter int ADDR_W      = 2,
    parameter int SYNC_STAGES = 2,
    parameter int HOLD_CYCLES = 8,
    parameter bit REGISTERED  = 1'b0,
    parameter int OUTS        = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              supply_ok,
    input  logic              shut_n,
    input  logic              glb_en_n,
    input  logic              grp1_en_n,
    input  logic              grp2_en,
    input  logic [ADDR_W-1:0] addr1,
    input  logic [ADDR_W-1:0] addr2,
    output logic [OUTS-1:0]   sel1_n,
    output logic [OUTS-1:0]   sel2_n,
    output logic              psw_n
);
    localparam int TOTAL = 2 * OUTS;

    logic          qual_ok;
    logic          pwr_gate;
    memsel_ctrl_t  ctrl;
    logic [OUTS-1:0] dec1_n;
    logic [OUTS-1:0] dec2_n;
    logic [TOTAL-1:0] dec_all_n;
    logic [TOTAL-1:0] out_all_n;

    memsel_supply_qual #(
        .SYNC_STAGES (SYNC_STAGES),
        .HOLD_CYCLES (HOLD_CYCLES)
    ) u_qual (
        .clk       (clk),
        .rst_n     (rst_n),
        .supply_ok (supply_ok),
        .qual_ok   (qual_ok)
    );

    // Power gate: raw input for an immediate drop, qualifier for recovery.
    always_comb begin
        pwr_gate      = supply_ok & qual_ok;
        ctrl.glb_en_n = glb_en_n;
        ctrl.shut_n   = shut_n;
        ctrl.pwr_gate = pwr_gate;
    end

    memsel_half_dec #(.ADDR_W(ADDR_W), .GRP_ACT_HIGH(1'b0)) u_half1 (
        .clk    (clk),
        .rst_n  (rst_n),
        .ctrl   (ctrl),
        .grp_en (grp1_en_n),
        .addr   (addr1),
        .sel_n  (dec1_n)
    );

    memsel_half_dec #(.ADDR_W(ADDR_W), .GRP_ACT_HIGH(1'b1)) u_half2 (
        .clk    (clk),
        .rst_n  (rst_n),
        .ctrl   (ctrl),
        .grp_en (grp2_en),
        .addr   (addr2),
        .sel_n  (dec2_n)
    );

    assign dec_all_n = {dec2_n, dec1_n};

    if (REGISTERED) begin : g_reg
        logic [TOTAL-1:0] out_q;
        // Capture the decoded selects; reset parks them inactive.
        always_ff @(posedge clk) begin
            if (!rst_n) out_q <= '1;
            else        out_q <= dec_all_n;
        end
        // The supply force bypasses the flops.
        assign out_all_n = out_q | {TOTAL{~supply_ok}};

        // R3: shutdown seen at an edge leaves all selects high after it.
        a_r3_shut_reg: assert property (@(posedge clk) disable iff (!rst_n)
            !shut_n |=> (&out_all_n));
    end else begin : g_comb
        // Drive the decoded selects straight through.
        assign out_all_n = dec_all_n;

        // R3: shutdown blocks every select in the same cycle.
        a_r3_shut_comb: assert property (@(posedge clk) disable iff (!rst_n)
            !shut_n |-> (&out_all_n));
    end

    // Split the output vector and drive the supply switch.
    always_comb begin
        sel1_n = out_all_n[OUTS-1:0];
        sel2_n = out_all_n[TOTAL-1:OUTS];
        psw_n  = ~pwr_gate;
    end

    // R5: a missing supply leaves no select low and the switch released.
    a_r5_fail_forces: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |-> ((&sel1_n) && (&sel2_n) && psw_n));

    // R6: any low select implies the supply switch is on.
    a_r6_switch_on: assert property (@(posedge clk) disable iff (!rst_n)
        !(&out_all_n) |-> !psw_n);

endmodule

// File: tb/tb_memsel_pwr_decoder.sv
// Bench: directed tests, one task per scenario, against a combinational
// instance (dut) and a registered instance (dut_reg) driven by the same inputs.
module tb_memsel_pwr_decoder;
    localparam int HOLD = 4;
    localparam int SYNC = 2;
    localparam int WAIT = SYNC + HOLD;

    logic clk = 1'b0;
    logic rst_n, supply_ok, shut_n, glb_en_n, grp1_en_n, grp2_en;
    logic [1:0] addr1, addr2;
    logic [3:0] s1, s2, r1, r2;
    logic psw, psw_r;
    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    memsel_pwr_decoder #(.SYNC_STAGES(SYNC), .HOLD_CYCLES(HOLD), .REGISTERED(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .shut_n(shut_n),
        .glb_en_n(glb_en_n), .grp1_en_n(grp1_en_n), .grp2_en(grp2_en),
        .addr1(addr1), .addr2(addr2), .sel1_n(s1), .sel2_n(s2), .psw_n(psw));

    memsel_pwr_decoder #(.SYNC_STAGES(SYNC), .HOLD_CYCLES(HOLD), .REGISTERED(1'b1)) dut_reg (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .shut_n(shut_n),
        .glb_en_n(glb_en_n), .grp1_en_n(grp1_en_n), .grp2_en(grp2_en),
        .addr1(addr1), .addr2(addr2), .sel1_n(r1), .sel2_n(r2), .psw_n(psw_r));

    // Expected half output: one low bit at addr when enabled.
    function automatic logic [3:0] exp_half(input logic en, input logic [1:0] a);
        return en ? ~(4'b0001 << a) : 4'b1111;
    endfunction

    task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // Drive all controls at a falling edge and let the logic settle.
    task automatic drive(input logic sh, input logic g, input logic e1, input logic e2,
                         input logic [1:0] a1, input logic [1:0] a2);
        @(negedge clk);
        shut_n = sh; glb_en_n = g; grp1_en_n = e1; grp2_en = e2;
        addr1 = a1; addr2 = a2;
        #1;
    endtask

    // Check the combinational instance now and the registered one after an edge.
    task automatic apply_chk(input string tag, input logic sh, input logic g,
                             input logic e1, input logic e2,
                             input logic [1:0] a1, input logic [1:0] a2);
        logic on;
        logic [8:0] exp;
        drive(sh, g, e1, e2, a1, a2);
        on  = sh & ~g;
        exp = {1'b0, exp_half(on & e2, a2), exp_half(on & ~e1, a1)};
        chk(tag, {psw, s2, s1}, exp);
        @(posedge clk); #1;
        chk({tag, " R8"}, {psw_r, r2, r1}, exp);
    endtask

    task automatic t_reset;
        @(negedge clk);
        rst_n = 1'b0; supply_ok = 1'b1;
        drive(1'b1, 1'b0, 1'b0, 1'b1, 2'd1, 2'd2);
        repeat (2) @(posedge clk);
        #1;
        chk("R10 comb", {psw, s2, s1}, 9'h1FF);
        chk("R10 reg", {psw_r, r2, r1}, 9'h1FF);
        @(negedge clk); rst_n = 1'b1;
        for (int k = 1; k <= WAIT; k++) begin
            @(posedge clk); #1;
            if (k < WAIT) chk("R7 after reset", {psw, s2, s1}, 9'h1FF);
        end
        chk("R7 reset release", {psw, s2, s1}, {1'b0, 4'b1011, 4'b1101});
    endtask

    task automatic t_half1;
        for (int a = 0; a < 4; a++)
            apply_chk("R1 half1", 1'b1, 1'b0, 1'b0, 1'b0, 2'(a), 2'(3 - a));
    endtask

    task automatic t_half2;
        for (int a = 0; a < 4; a++)
            apply_chk("R2 half2", 1'b1, 1'b0, 1'b1, 1'b1, 2'(3 - a), 2'(a));
    endtask

    task automatic t_disable;
        apply_chk("R3 global off", 1'b1, 1'b1, 1'b0, 1'b1, 2'd2, 2'd1);
        apply_chk("R3 shutdown", 1'b0, 1'b0, 1'b0, 1'b1, 2'd3, 2'd0);
        apply_chk("R3 grp1 off", 1'b1, 1'b0, 1'b1, 1'b0, 2'd1, 2'd1);
        apply_chk("R3 grp2 off", 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 2'd3);
    endtask

    task automatic t_both;
        apply_chk("R9 both halves", 1'b1, 1'b0, 1'b0, 1'b1, 2'd3, 2'd0);
        chk("R9 one low per half", 9'($countones(~s1)) + 9'($countones(~s2)), 9'd2);
    endtask

    task automatic t_cascade;
        for (int v = 0; v < 8; v++) begin
            logic c;
            logic [1:0] ba;
            logic [7:0] exp8;
            c = v[2]; ba = v[1:0];
            drive(1'b1, 1'b0, c, c, ba, ba);
            exp8 = ~(8'b1 << v);
            chk("R4 cascade", {1'b0, s2, s1}, {1'b0, exp8});
        end
    endtask

    task automatic t_power;
        drive(1'b1, 1'b0, 1'b0, 1'b1, 2'd2, 2'd3);
        @(posedge clk); #1;
        chk("R6 switch on", {psw, psw_r}, 9'd0);
        @(negedge clk); supply_ok = 1'b0; #1;
        chk("R5 fail comb", {psw, s2, s1}, 9'h1FF);
        chk("R5 fail reg", {psw_r, r2, r1}, 9'h1FF);
        drive(1'b1, 1'b0, 1'b0, 1'b1, 2'd0, 2'd1);
        chk("R5 inputs ignored", {psw, s2, s1, r2, r1} == 17'h1FFFF ? 9'd1 : 9'd0, 9'd1);
        @(negedge clk); supply_ok = 1'b1;
        for (int k = 1; k <= WAIT + 1; k++) begin
            @(posedge clk); #1;
            if (k < WAIT) chk("R7 hold comb", {psw, s2, s1}, 9'h1FF);
            if (k == WAIT) chk("R7 recovered comb", {psw, s2, s1}, {1'b0, 4'b1101, 4'b1110});
            if (k == WAIT) chk("R8 reg lags", {r2, r1}, 9'h0FF);
            if (k == WAIT + 1) chk("R8 reg recovered", {psw_r, r2, r1}, {1'b0, 4'b1101, 4'b1110});
        end
    endtask

    initial begin
        rst_n = 1'b0; supply_ok = 1'b1; shut_n = 1'b1; glb_en_n = 1'b1;
        grp1_en_n = 1'b1; grp2_en = 1'b0; addr1 = '0; addr2 = '0;
        t_reset();
        t_half1();
        t_half2();
        t_disable();
        t_both();
        t_cascade();
        t_power();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule